// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a direct-mapped cache controller backed by a small fully associative buffer of recently evicted lines. The processor side presents one word request at a time (word address, read or write, write data). A response comes back with the data word and two flags. One flag marks a hit in the primary array. The other marks a hit in the victim buffer.

The primary array and the victim buffer are searched in the same cycle. A primary hit is answered at once. It leaves both structures unchanged, apart from the data and dirty bit on a write. A victim hit swaps the requested line with the line occupying its primary set, so two conflicting lines can alternate without memory traffic. When both miss, the line is fetched from the next level over a valid/ready request channel with a separate response strobe. The valid line it displaces then moves into the victim buffer. If the buffer is full, its least recently used entry is overwritten, and that entry is written back first if it is dirty.

Top module: `vc_cache`

## Requirements
- R1: After reset every line in both structures is invalid; req_ready_o is 1, resp_valid_o and mem_req_valid_o are 0, and the first access to any address misses (resp_hit_o=0, resp_vhit_o=0) and fetches one line.
- R2: A primary hit raises resp_valid_o with resp_hit_o=1 one cycle after acceptance, issues no memory request, and changes neither which lines are held nor the victim recency order.
- R3: A primary miss that hits the victim buffer swaps the two lines: resp_vhit_o=1 one cycle after acceptance with no memory request, the requested line then hits in the primary array, and the displaced line then hits in the victim buffer.
- R4: After a swap, the victim entry holding the displaced line becomes most recently used, and the other victim entry keeps its line.
- R5: A miss in both issues a read on the memory channel with line address = word address >> log2(LINE_WORDS), where word k of a line sits at bits [k*DATA_W +: DATA_W]. It fills the primary set from mem_resp_data_i and responds with both flags 0 one cycle after mem_resp_valid_i.
- R6: On a double miss with a valid displaced line and a full victim buffer, the least recently used victim entry is replaced. If that entry is dirty, it is written first (mem_req_write_o=1, its line address and data), and the read request follows.
- R7: A line address is never held in both structures at once, so at most one of the two lookups hits.
- R8: A displaced primary line that is invalid is not inserted into the victim buffer.
- R9: A write updates the addressed word in whichever structure supplies the line, returns the written word on resp_rdata_o, and marks the line dirty. A write miss allocates exactly like a read miss. A read returns the most recently written value of its word.
- R10: For two addresses alternating in the same primary set, only the first two accesses fetch from memory.
- R11: A memory request holds its valid, address and direction until accepted by mem_req_ready_i, and no processor request is accepted while a miss is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Controller idle, request accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| resp_valid_o | output | 1 | Response strobe, one cycle |
| resp_hit_o | output | 1 | Served by the primary array |
| resp_vhit_o | output | 1 | Served by a victim swap |
| resp_rdata_o | output | DATA_W | Word read, or word written |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_write_o | output | 1 | 1 = writeback, 0 = line read |
| mem_req_addr_o | output | ADDR_W-log2(LINE_WORDS) | Line address |
| mem_req_wdata_o | output | LINE_WORDS*DATA_W | Writeback line |
| mem_resp_valid_i | input | 1 | Read line returned |
| mem_resp_data_i | input | LINE_WORDS*DATA_W | Returned line |

## Verification
The hardest state to reach is a full victim buffer whose least recently used entry is dirty at the moment another double miss displaces a valid line. That state needs a write followed by several conflicting misses in one set, in the right order. Directed sequences build it on purpose: a write, then three further lines in the same set. A long pseudo-random run over a small address window also reaches it many times. The bench keeps its own line-list model of both structures, so every access has a predicted class, fetch count and writeback. A memory responder with a stalling ready and a delayed response drives the handshake through its waiting states.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_RD   = 2'd2,
    ST_WAIT = 2'd3
  } vc_state_e;
endpackage

// File: rtl/vc_primary.sv
module vc_primary #(
  parameter int TAG_W  = 4,
  parameter int IDX_W  = 2,
  parameter int LINE_W = 32,
  parameter int SETS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic              rd_dirty_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [LINE_W-1:0] rd_line_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic              wr_dirty_i
);
  logic [SETS-1:0]   vld_q, dty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      dty_q <= '0;
    end else if (wr_en_i) begin
      vld_q[wr_idx_i] <= 1'b1;
      dty_q[wr_idx_i] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      line_q[wr_idx_i] <= wr_line_i;
    end
  end

  assign rd_valid_o = vld_q[rd_idx_i];
  assign rd_dirty_o = dty_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_line_o  = line_q[rd_idx_i];
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int LA_W    = 7,
  parameter int LINE_W  = 32,
  parameter int VICTIMS = 2,
  localparam int VI_W   = $clog2(VICTIMS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LA_W-1:0]   look_la_i,
  output logic              hit_o,
  output logic [VI_W-1:0]   hit_slot_o,
  output logic [LINE_W-1:0] hit_line_o,
  output logic              hit_dirty_o,
  output logic [VI_W-1:0]   tgt_slot_o,
  output logic              tgt_valid_o,
  output logic              tgt_dirty_o,
  output logic [LA_W-1:0]   tgt_la_o,
  output logic [LINE_W-1:0] tgt_line_o,
  input  logic              wr_en_i,
  input  logic [VI_W-1:0]   wr_slot_i,
  input  logic [LA_W-1:0]   wr_la_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic              wr_dirty_i
);
  logic [VICTIMS-1:0] vld_q, dty_q;
  logic [VI_W-1:0]    age_q  [VICTIMS];  // 0 = most recently used
  logic [LA_W-1:0]    la_q   [VICTIMS];
  logic [LINE_W-1:0]  line_q [VICTIMS];
  logic [VI_W-1:0]    lru_slot, inv_slot;
  logic               inv_found;

  always_comb begin
    hit_o      = 1'b0;
    hit_slot_o = '0;
    lru_slot   = '0;
    inv_slot   = '0;
    inv_found  = 1'b0;
    for (int i = 0; i < VICTIMS; i++) begin
      if (vld_q[i] && la_q[i] == look_la_i) begin
        hit_o      = 1'b1;
        hit_slot_o = VI_W'(i);
      end
      if (age_q[i] == VI_W'(VICTIMS - 1)) lru_slot = VI_W'(i);
    end
    for (int i = VICTIMS - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        inv_slot  = VI_W'(i);
        inv_found = 1'b1;
      end
    end
  end

  assign hit_line_o  = line_q[hit_slot_o];
  assign hit_dirty_o = dty_q[hit_slot_o];
  assign tgt_slot_o  = inv_found ? inv_slot : lru_slot;
  assign tgt_valid_o = vld_q[tgt_slot_o];
  assign tgt_dirty_o = dty_q[tgt_slot_o];
  assign tgt_la_o    = la_q[tgt_slot_o];
  assign tgt_line_o  = line_q[tgt_slot_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      dty_q <= '0;
      for (int i = 0; i < VICTIMS; i++) age_q[i] <= VI_W'(i);
    end else if (wr_en_i) begin
      vld_q[wr_slot_i] <= 1'b1;
      dty_q[wr_slot_i] <= wr_dirty_i;
      for (int i = 0; i < VICTIMS; i++) begin
        if (VI_W'(i) == wr_slot_i)              age_q[i] <= '0;
        else if (age_q[i] < age_q[wr_slot_i])   age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      la_q[wr_slot_i]   <= wr_la_i;
      line_q[wr_slot_i] <= wr_line_i;
    end
  end
endmodule

// File: rtl/vc_cache.sv
module vc_cache #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int LINE_WORDS = 2,
  parameter int SETS       = 4,
  parameter int VICTIMS    = 2,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int LA_W   = ADDR_W - OFF_W,
  localparam int TAG_W  = LA_W - IDX_W,
  localparam int LINE_W = LINE_WORDS * DATA_W,
  localparam int VI_W   = $clog2(VICTIMS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic              resp_vhit_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_write_o,
  output logic [LA_W-1:0]   mem_req_addr_o,
  output logic [LINE_W-1:0] mem_req_wdata_o,
  input  logic              mem_resp_valid_i,
  input  logic [LINE_W-1:0] mem_resp_data_i
);
  import vc_pkg::*;

  vc_state_e         state_q;
  logic              p_write_q;
  logic [ADDR_W-1:0] p_addr_q;
  logic [DATA_W-1:0] p_wdata_q;

  logic              idle, accept, fill;
  logic              cur_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wd;
  logic [LA_W-1:0]   cur_la;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic [OFF_W-1:0]  cur_off;

  logic              pr_valid, pr_dirty;
  logic [TAG_W-1:0]  pr_tag;
  logic [LINE_W-1:0] pr_line;
  logic              pri_hit, vic_hit;

  logic [VI_W-1:0]   vb_hit_slot, vb_tgt_slot;
  logic [LINE_W-1:0] vb_hit_line, vb_tgt_line;
  logic              vb_hit_dirty, vb_tgt_valid, vb_tgt_dirty;
  logic [LA_W-1:0]   vb_tgt_la;

  logic              pw_en, pw_dirty, vw_en;
  logic [VI_W-1:0]   vw_slot;
  logic [LINE_W-1:0] base_line, new_line;
  logic [DATA_W-1:0] out_word;

  assign idle     = (state_q == ST_IDLE);
  assign accept   = idle && req_valid_i;
  assign fill     = (state_q == ST_WAIT) && mem_resp_valid_i;
  assign cur_addr = idle ? req_addr_i  : p_addr_q;
  assign cur_wr   = idle ? req_write_i : p_write_q;
  assign cur_wd   = idle ? req_wdata_i : p_wdata_q;
  assign cur_la   = cur_addr[ADDR_W-1:OFF_W];
  assign cur_idx  = cur_la[IDX_W-1:0];
  assign cur_tag  = cur_la[LA_W-1:IDX_W];
  assign cur_off  = cur_addr[OFF_W-1:0];

  vc_primary #(.TAG_W(TAG_W), .IDX_W(IDX_W), .LINE_W(LINE_W), .SETS(SETS)) u_pri (
    .clk_i, .rst_ni,
    .rd_idx_i(cur_idx), .rd_valid_o(pr_valid), .rd_dirty_o(pr_dirty),
    .rd_tag_o(pr_tag), .rd_line_o(pr_line),
    .wr_en_i(pw_en), .wr_idx_i(cur_idx), .wr_tag_i(cur_tag),
    .wr_line_i(new_line), .wr_dirty_i(pw_dirty)
  );

  vc_victim_buf #(.LA_W(LA_W), .LINE_W(LINE_W), .VICTIMS(VICTIMS)) u_vb (
    .clk_i, .rst_ni,
    .look_la_i(cur_la), .hit_o(vic_hit), .hit_slot_o(vb_hit_slot),
    .hit_line_o(vb_hit_line), .hit_dirty_o(vb_hit_dirty),
    .tgt_slot_o(vb_tgt_slot), .tgt_valid_o(vb_tgt_valid), .tgt_dirty_o(vb_tgt_dirty),
    .tgt_la_o(vb_tgt_la), .tgt_line_o(vb_tgt_line),
    .wr_en_i(vw_en), .wr_slot_i(vw_slot), .wr_la_i({pr_tag, cur_idx}),
    .wr_line_i(pr_line), .wr_dirty_i(pr_dirty)
  );

  assign pri_hit = pr_valid && (pr_tag == cur_tag);

  always_comb begin
    base_line = fill ? mem_resp_data_i : (pri_hit ? pr_line : vb_hit_line);
    new_line  = base_line;
    if (cur_wr) new_line[cur_off*DATA_W +: DATA_W] = cur_wd;
    out_word  = new_line[cur_off*DATA_W +: DATA_W];
    pw_en     = 1'b0;
    pw_dirty  = 1'b0;
    vw_en     = 1'b0;
    vw_slot   = vb_tgt_slot;
    if (accept && pri_hit) begin
      pw_en    = cur_wr;
      pw_dirty = 1'b1;
    end else if (accept && vic_hit) begin
      pw_en    = 1'b1;
      pw_dirty = vb_hit_dirty | cur_wr;
      vw_en    = pr_valid;
      vw_slot  = vb_hit_slot;
    end else if (fill) begin
      pw_en    = 1'b1;
      pw_dirty = cur_wr;
      vw_en    = pr_valid;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      p_write_q <= 1'b0;
      p_addr_q  <= '0;
      p_wdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept && !pri_hit && !vic_hit) begin
          p_write_q <= req_write_i;
          p_addr_q  <= req_addr_i;
          p_wdata_q <= req_wdata_i;
          state_q   <= (pr_valid && vb_tgt_valid && vb_tgt_dirty) ? ST_WB : ST_RD;
        end
        ST_WB:   if (mem_req_ready_i)  state_q <= ST_RD;
        ST_RD:   if (mem_req_ready_i)  state_q <= ST_WAIT;
        ST_WAIT: if (mem_resp_valid_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_vhit_o  <= 1'b0;
      resp_rdata_o <= '0;
    end else begin
      resp_valid_o <= (accept && (pri_hit || vic_hit)) || fill;
      resp_hit_o   <= accept && pri_hit;
      resp_vhit_o  <= accept && !pri_hit && vic_hit;
      if ((accept && (pri_hit || vic_hit)) || fill) resp_rdata_o <= out_word;
    end
  end

  assign req_ready_o     = idle;
  assign mem_req_valid_o = (state_q == ST_WB) || (state_q == ST_RD);
  assign mem_req_write_o = (state_q == ST_WB);
  assign mem_req_addr_o  = (state_q == ST_WB) ? vb_tgt_la : p_addr_q[ADDR_W-1:OFF_W];
  assign mem_req_wdata_o = vb_tgt_line;
endmodule

// File: rtl/vc_cache_chk.sv
module vc_cache_chk #(
  parameter int LA_W = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            resp_valid_o,
  input logic            resp_hit_o,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic            mem_req_write_o,
  input logic [LA_W-1:0] mem_req_addr_o,
  input logic            pri_hit,
  input logic            vic_hit
);
  assert_excl_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |-> !(pri_hit && vic_hit));

  assert_hit_resp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && pri_hit) |=> (resp_valid_o && resp_hit_o && !mem_req_valid_o));

  assert_swap_resp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && vic_hit) |=> (resp_valid_o && !mem_req_valid_o));

  assert_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_write_o)));

  assert_wb_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_write_o && mem_req_ready_i) |=> (mem_req_valid_o && !mem_req_write_o));
endmodule

bind vc_cache vc_cache_chk #(.LA_W(LA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o), .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i), .mem_req_write_o(mem_req_write_o),
  .mem_req_addr_o(mem_req_addr_o), .pri_hit(pri_hit), .vic_hit(vic_hit)
);

// File: tb/vc_cache_test.sv
`timescale 1ns/1ps
module vc_cache_test;
  localparam int AW = 8, DW = 16, LW = 2, SETS = 4, VICT = 2;
  localparam int LAW = AW - 1, LINEW = LW * DW, WORDS = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic resp_valid, resp_hit, resp_vhit;
  logic [DW-1:0] resp_rdata;
  logic mem_req_valid, mem_req_ready, mem_req_write;
  logic [LAW-1:0] mem_req_addr;
  logic [LINEW-1:0] mem_req_wdata;
  logic mem_resp_valid;
  logic [LINEW-1:0] mem_resp_data;

  always #10 clk = ~clk;

  vc_cache #(.ADDR_W(AW), .DATA_W(DW), .LINE_WORDS(LW), .SETS(SETS), .VICTIMS(VICT)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .resp_valid_o(resp_valid), .resp_hit_o(resp_hit), .resp_vhit_o(resp_vhit),
    .resp_rdata_o(resp_rdata),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_write_o(mem_req_write), .mem_req_addr_o(mem_req_addr),
    .mem_req_wdata_o(mem_req_wdata),
    .mem_resp_valid_i(mem_resp_valid), .mem_resp_data_i(mem_resp_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] gold [WORDS];
  int rd_cnt = 0, wb_cnt = 0, rd_la = 0, wb_la = -1, pend = 0, cyc = 0;

  // bench model: primary sets and victim list (index 0 = most recent)
  bit pv [SETS];
  bit pd [SETS];
  int pla [SETS];
  int vq_la [$];
  bit vq_d [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LINEW-1:0] line_of(input int la);
    logic [LINEW-1:0] l;
    for (int k = 0; k < LW; k++) l[k*DW +: DW] = mem[la*LW + k];
    return l;
  endfunction

  // memory responder: ready stalls every third cycle, data two cycles after read accept
  initial begin
    mem_req_ready = 1'b0; mem_resp_valid = 1'b0; mem_resp_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_resp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin mem_resp_valid = 1'b1; mem_resp_data = line_of(rd_la); end
      end
      mem_req_ready = (cyc % 3) != 0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          for (int k = 0; k < LW; k++) mem[int'(mem_req_addr)*LW + k] = mem_req_wdata[k*DW +: DW];
          wb_cnt++; wb_la = int'(mem_req_addr);
        end else begin
          rd_cnt++; rd_la = int'(mem_req_addr); pend = 2;
        end
      end
    end
  end

  function automatic void model(input bit wr, input int la, output int cls, output int wbx, output int evla);
    int idx = la % SETS;
    int found = -1;
    bit vd;
    wbx = 0; evla = -1;
    if (pv[idx] && pla[idx] == la) begin
      cls = 0;
      if (wr) pd[idx] = 1;
    end else begin
      for (int i = 0; i < vq_la.size(); i++) if (vq_la[i] == la) found = i;
      if (found >= 0) begin
        cls = 1; vd = vq_d[found];
        vq_la.delete(found); vq_d.delete(found);
        vq_la.push_front(pla[idx]); vq_d.push_front(pd[idx]);
        pla[idx] = la; pd[idx] = vd | wr;
      end else begin
        cls = 2;
        if (pv[idx]) begin
          if (vq_la.size() == VICT) begin
            evla = vq_la.pop_back();
            if (vq_d.pop_back()) wbx = 1;
          end
          vq_la.push_front(pla[idx]); vq_d.push_front(pd[idx]);
        end
        pv[idx] = 1; pla[idx] = la; pd[idx] = wr;
      end
    end
  endfunction

  task automatic access(input bit wr, input int a, input logic [DW-1:0] d, input string tag);
    int cls, wbx, evla, r0, w0, n, ecls;
    logic [DW-1:0] exp_d;
    model(wr, a / LW, cls, wbx, evla);
    r0 = rd_cnt; w0 = wb_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!resp_valid && n < 60) begin @(negedge clk); n++; end
    chk(resp_valid, {tag, " response"}, int'(resp_valid), 1);
    ecls = (cls == 0) ? 1 : (cls == 1) ? 2 : 0;
    chk({resp_vhit, resp_hit} == 2'(ecls), {tag, " class"}, int'({resp_vhit, resp_hit}), ecls);
    exp_d = wr ? d : gold[a];
    chk(resp_rdata == exp_d, {tag, " data R9"}, int'(resp_rdata), int'(exp_d));
    if (wr) gold[a] = d;
    chk(rd_cnt - r0 == int'(cls == 2), {tag, " fetch count R5"}, rd_cnt - r0, int'(cls == 2));
    chk(wb_cnt - w0 == wbx, {tag, " writeback R6"}, wb_cnt - w0, wbx);
    if (wbx == 1) chk(wb_la == evla, {tag, " writeback address R6"}, wb_la, evla);
  endtask

  task automatic do_reset();
    req_valid = 1'b0;
    rst_n = 1'b0;
    for (int s = 0; s < SETS; s++) begin pv[s] = 0; pd[s] = 0; pla[s] = 0; end
    vq_la.delete(); vq_d.delete();
    for (int i = 0; i < WORDS; i++) gold[i] = mem[i];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    int r0;
    for (int i = 0; i < WORDS; i++) mem[i] = DW'(i * 16'h0107 ^ 16'h5a3c);
    do_reset();
    // R1: idle outputs after reset, first access misses
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(resp_valid == 1'b0, "R1 resp idle after reset", int'(resp_valid), 0);
    chk(mem_req_valid == 1'b0, "R1 mem idle after reset", int'(mem_req_valid), 0);
    // R10: alternating pair in set 0 (line 0 and line 4)
    r0 = rd_cnt;
    for (int k = 0; k < 8; k++) access(0, (k % 2) ? 8 : 0, '0, "R10 R3 alternate");
    chk(rd_cnt - r0 == 2, "R10 total fetches", rd_cnt - r0, 2);
    // R2: repeated hit keeps state
    access(0, 9, '0, "R2 hit");
    access(0, 9, '0, "R2 hit again");
    access(0, 0, '0, "R2 then swap R3");
    // R8: invalid primary lines not inserted
    do_reset();
    access(0, 0, '0, "R8 L1");
    access(0, 2, '0, "R8 set1 first");
    access(0, 4, '0, "R8 set2 first");
    access(0, 6, '0, "R8 set3 first");
    access(0, 8, '0, "R8 L2");
    access(0, 16, '0, "R8 L3");
    access(0, 0, '0, "R8 L1 still in victim");
    chk(resp_vhit == 1'b1, "R8 L1 victim hit", int'(resp_vhit), 1);
    // R4: swap promotes displaced line, LRU retained
    do_reset();
    access(0, 0, '0, "R4 A");
    access(0, 8, '0, "R4 B");
    access(0, 16, '0, "R4 C");
    access(0, 1, '0, "R4 A swap");
    access(0, 9, '0, "R4 B kept as LRU");
    chk(resp_vhit == 1'b1, "R4 LRU entry kept", int'(resp_vhit), 1);
    // R6 R9: dirty line written back when evicted from full victim buffer
    do_reset();
    access(1, 1, 16'hbeef, "R9 write miss");
    access(0, 8, '0, "R6 fill2");
    access(0, 16, '0, "R6 fill3");
    access(0, 24, '0, "R6 evict dirty");
    chk(mem[1] == 16'hbeef, "R6 written-back word", int'(mem[1]), 16'hbeef);
    access(0, 1, '0, "R9 reread after writeback");
    // R7 R5: pseudo-random mix over a small window
    do_reset();
    lfsr = 8'h5b;
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      access(lfsr[0] & lfsr[6], int'(lfsr[5:0]), DW'(k * 37 + 5), "R7 R5 random");
    end
    // R5: sequential sweep of the whole space
    for (int a = 0; a < WORDS; a++) access(0, a, '0, "R5 sweep");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule